// File: doc/BRIEF.md
# Interrupt Distributor Register File

This block is the byte-addressed state store of an interrupt distributor. For every interrupt ID below a configured line count it keeps an enable bit, a pending bit, an eight-bit priority, a CPU target mask and a two-bit trigger configuration. It also holds a global distributor enable. A host reads and writes single bytes at twelve-bit offsets. Each offset window maps onto one kind of per-ID state. Any access that works out to an ID at or above the line count is refused.

IDs 0 to 31 are internal to the controller. Only IDs from 32 upward have input pins, so there are `NUM_LINES - 32` pins. A rising edge on a pin marks its ID pending. Some low IDs have fixed behaviour. IDs 0 to 15 cannot be disabled. The target field cannot be written for IDs below 29. IDs 29 to 31 always report the requesting CPU as their target. IDs 0 to 31 always have the upper bit of each configuration pair set. Choosing which interrupt to deliver is left to a separate block.

Top module: `idist_regfile`

## Requirements
- R1: After reset, the distributor enable, every enable bit, every pending bit, every priority, every target mask and every configuration pair are zero, and `rdata` is zero.
- R2: Offset 0x000 is the distributor enable, read and written through bit 0. Offset 0x004 is read-only. It returns `NUM_LINES/32 - 1` in bits 4:0 and `NUM_CPUS - 1` in bits 7:5. Every other offset below 0x100 reads as zero and ignores writes.
- R3: Byte k of the window at 0x100 sets enables and byte k of the window at 0x180 clears them. In both windows, bit j acts on ID 8k+j and only where bit j is one. A read of either window returns the eight enable bits.
- R4: A set-enable write to a byte covering IDs 0 to 15 sets all eight enables whatever the data. A clear-enable write to such a byte has no effect.
- R5: The windows at 0x200 and 0x280 set and clear pending bits, with the same bit layout as R3. Reads of either window return the pending bits. The window at 0x300 (8 IDs per byte) reads as zero for in-range IDs.
- R6: Offset 0x400+id is the priority byte of that ID, readable and writable.
- R7: Offset 0x800+id is the target mask, held in the low `NUM_CPUS` bits; upper bits read zero. Writes for IDs below 29 are ignored. Reads for IDs 29, 30 and 31 return a byte with only bit `cpu_id` set.
- R8: At offset 0xC00+k, bits 2j+1:2j hold the configuration pair of ID 4k+j. A write to a byte covering IDs below 32 has 0xAA ORed into its data first.
- R9: An access in any per-ID window whose first ID is at or above `NUM_LINES` reads zero and changes nothing. The same holds for offsets 0xF00 and above.
- R10: A rising edge on `ext_irq[n]`, sampled at a clock edge, sets the pending bit of ID n+32 at that edge. A pin held high does not set it again. If a clear-pending write hits the same bit in the same cycle, the set wins.
- R11: `rdata` is registered. It loads at a clock edge where `rd_en` is high and holds otherwise. A read returns the state as it was before any write or edge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 12 | Byte offset |
| wdata | input | 8 | Write data |
| cpu_id | input | CPU_W | Index of the CPU making the access |
| ext_irq | input | NUM_LINES-32 | External interrupt pins, pin n maps to ID n+32 |
| rdata | output | 8 | Registered read data |

## Verification
The assertions assume that the inputs change only between clock edges and that `cpu_id` is below `NUM_CPUS` whenever a target read is made. They also assume that `ext_irq` is low during reset, so that the first sampled edge is a real one. The bench drives every input on the falling edge, uses only CPU indices 0 to 3 with four CPUs, and holds the pins low until reset has ended. A behavioural model, written with integer arithmetic over the offsets, predicts `rdata` on every clock.

// File: rtl/idist_pkg.sv
package idist_pkg;

    localparam int MAX_LINES    = 1020;
    localparam int INTERNAL_IDS = 32;
    localparam int ID_W         = 12;

    typedef enum logic [3:0] {
        WIN_CTRL,
        WIN_SETEN,
        WIN_CLREN,
        WIN_SETPND,
        WIN_CLRPND,
        WIN_ACTIVE,
        WIN_PRIO,
        WIN_TARGET,
        WIN_CFG,
        WIN_NONE
    } win_e;

    typedef struct packed {
        win_e            win;
        logic [ID_W-1:0] base;   // first interrupt ID covered by the byte
        logic [7:0]      ofs;    // low offset byte, used in the control window
        logic            bad;    // out-of-range or unmapped access
    } acc_t;

    function automatic acc_t decode(input logic [11:0] a, input int unsigned lines);
        acc_t r;
        r.win  = WIN_NONE;
        r.base = '0;
        r.ofs  = a[7:0];
        if (a < 12'h100) begin
            r.win = WIN_CTRL;
        end else if (a < 12'h180) begin
            r.win  = WIN_SETEN;
            r.base = {2'b00, a[6:0], 3'b000};
        end else if (a < 12'h200) begin
            r.win  = WIN_CLREN;
            r.base = {2'b00, a[6:0], 3'b000};
        end else if (a < 12'h280) begin
            r.win  = WIN_SETPND;
            r.base = {2'b00, a[6:0], 3'b000};
        end else if (a < 12'h300) begin
            r.win  = WIN_CLRPND;
            r.base = {2'b00, a[6:0], 3'b000};
        end else if (a < 12'h400) begin
            r.win  = WIN_ACTIVE;
            r.base = {1'b0, a[7:0], 3'b000};
        end else if (a < 12'h800) begin
            r.win  = WIN_PRIO;
            r.base = {2'b00, a[9:0]};
        end else if (a < 12'hC00) begin
            r.win  = WIN_TARGET;
            r.base = {2'b00, a[9:0]};
        end else if (a < 12'hF00) begin
            r.win  = WIN_CFG;
            r.base = {a[9:0], 2'b00};
        end
        case (r.win)
            WIN_CTRL: r.bad = 1'b0;
            WIN_NONE: r.bad = 1'b1;
            default:  r.bad = (32'(r.base) >= lines);
        endcase
        return r;
    endfunction

    function automatic logic [7:0] type_byte(input int lines, input int cpus);
        return 8'(((lines / 32) - 1) | ((cpus - 1) << 5));
    endfunction

endpackage

// File: rtl/idist_decode.sv
module idist_decode
    import idist_pkg::*;
#(
    parameter int N = 96
) (
    input  logic [11:0] addr,
    output acc_t        acc
);
    always_comb acc = decode(addr, N);
endmodule

// File: rtl/idist_store.sv
module idist_store
    import idist_pkg::*;
#(
    parameter int N    = 96,
    parameter int CPUS = 4,
    localparam int PINS = N - INTERNAL_IDS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  acc_t                      acc,
    input  logic [7:0]                wdata,
    input  logic [PINS-1:0]           ext_irq,
    output logic                      dist_en,
    output logic [N-1:0]              en_vec,
    output logic [N-1:0]              pend_vec,
    output logic [N-1:0]              rise_vec,
    output logic [N-1:0][7:0]         prio_vec,
    output logic [N-1:0][CPUS-1:0]    tgt_vec,
    output logic [N-1:0][1:0]         cfg_vec
);
    logic [PINS-1:0] ext_prev;
    logic            wok;

    assign wok = wr_en && !acc.bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_prev <= '0;
            dist_en  <= 1'b0;
        end else begin
            ext_prev <= ext_irq;
            if (wok && acc.win == WIN_CTRL && acc.ofs == 8'h00)
                dist_en <= wdata[0];
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        localparam int LANE = i % 8;
        localparam int GRP  = i / 8;
        localparam int QGRP = i / 4;
        localparam int PAIR = i % 4;

        logic            hit8, hit4, hit1;
        logic            set_en, clr_en, set_pd, clr_pd, rise;
        logic [7:0]      cfg_src;
        logic            en_r, pd_r;
        logic [7:0]      pr_r;
        logic [CPUS-1:0] tg_r;
        logic [1:0]      cf_r;

        assign hit8 = (int'(acc.base >> 3) == GRP);
        assign hit4 = (int'(acc.base >> 2) == QGRP);
        assign hit1 = (int'(acc.base) == i);

        assign set_en = wok && hit8 && acc.win == WIN_SETEN
                        && ((i < 16) ? 1'b1 : wdata[LANE]);
        assign clr_en = wok && hit8 && acc.win == WIN_CLREN
                        && ((i < 16) ? 1'b0 : wdata[LANE]);
        assign set_pd = wok && hit8 && acc.win == WIN_SETPND && wdata[LANE];
        assign clr_pd = wok && hit8 && acc.win == WIN_CLRPND && wdata[LANE];
        assign cfg_src = wdata | ((i < INTERNAL_IDS) ? 8'hAA : 8'h00);

        if (i >= INTERNAL_IDS) begin : g_pin
            assign rise = ext_irq[i-INTERNAL_IDS] & ~ext_prev[i-INTERNAL_IDS];
        end else begin : g_nopin
            assign rise = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                en_r <= 1'b0;
                pd_r <= 1'b0;
                pr_r <= '0;
                tg_r <= '0;
                cf_r <= '0;
            end else begin
                if (set_en)
                    en_r <= 1'b1;
                else if (clr_en)
                    en_r <= 1'b0;
                pd_r <= (pd_r & ~clr_pd) | set_pd | rise;
                if (wok && hit1 && acc.win == WIN_PRIO)
                    pr_r <= wdata;
                if (wok && hit1 && acc.win == WIN_TARGET && i >= 29)
                    tg_r <= wdata[CPUS-1:0];
                if (wok && hit4 && acc.win == WIN_CFG)
                    cf_r <= cfg_src[2*PAIR +: 2];
            end
        end

        assign en_vec[i]   = en_r;
        assign pend_vec[i] = pd_r;
        assign rise_vec[i] = rise;
        assign prio_vec[i] = pr_r;
        assign tgt_vec[i]  = tg_r;
        assign cfg_vec[i]  = cf_r;
    end
endmodule

// File: rtl/idist_rdmux.sv
module idist_rdmux
    import idist_pkg::*;
#(
    parameter int N     = 96,
    parameter int CPUS  = 4,
    parameter int CPU_W = 2
) (
    input  acc_t                   acc,
    input  logic [CPU_W-1:0]       cpu_id,
    input  logic                   dist_en,
    input  logic [N-1:0]           en_vec,
    input  logic [N-1:0]           pend_vec,
    input  logic [N-1:0][7:0]      prio_vec,
    input  logic [N-1:0][CPUS-1:0] tgt_vec,
    input  logic [N-1:0][1:0]      cfg_vec,
    output logic [7:0]             rd_byte
);
    localparam logic [7:0] TYPE_VAL = type_byte(N, CPUS);

    always_comb begin
        rd_byte = '0;
        if (!acc.bad) begin
            case (acc.win)
                WIN_CTRL: begin
                    if (acc.ofs == 8'h00)
                        rd_byte = {7'b0, dist_en};
                    else if (acc.ofs == 8'h04)
                        rd_byte = TYPE_VAL;
                end
                WIN_SETEN, WIN_CLREN: begin
                    for (int k = 0; k < N; k++)
                        if (int'(acc.base >> 3) == k / 8)
                            rd_byte[3'(k % 8)] = en_vec[k];
                end
                WIN_SETPND, WIN_CLRPND: begin
                    for (int k = 0; k < N; k++)
                        if (int'(acc.base >> 3) == k / 8)
                            rd_byte[3'(k % 8)] = pend_vec[k];
                end
                WIN_PRIO: begin
                    for (int k = 0; k < N; k++)
                        if (int'(acc.base) == k)
                            rd_byte = prio_vec[k];
                end
                WIN_TARGET: begin
                    if (acc.base >= 12'd29 && acc.base <= 12'd31) begin
                        rd_byte[cpu_id] = 1'b1;
                    end else begin
                        for (int k = 0; k < N; k++)
                            if (int'(acc.base) == k)
                                rd_byte[CPUS-1:0] = tgt_vec[k];
                    end
                end
                WIN_CFG: begin
                    for (int k = 0; k < N; k++)
                        if (int'(acc.base >> 2) == k / 4)
                            rd_byte[3'(2 * (k % 4)) +: 2] = cfg_vec[k];
                end
                default: rd_byte = '0;
            endcase
        end
    end
endmodule

// File: rtl/idist_regfile.sv
module idist_regfile
    import idist_pkg::*;
#(
    parameter int NUM_LINES = 96,
    parameter int NUM_CPUS  = 4,
    localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int EXT_PINS = NUM_LINES - INTERNAL_IDS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [11:0]         addr,
    input  logic [7:0]          wdata,
    input  logic [CPU_W-1:0]    cpu_id,
    input  logic [EXT_PINS-1:0] ext_irq,
    output logic [7:0]          rdata
);
    if (NUM_LINES % 32 != 0 || NUM_LINES < 64 || NUM_LINES > MAX_LINES
        || NUM_CPUS < 1 || NUM_CPUS > 8) begin : g_cfg_err
        $error("idist_regfile: unsupported NUM_LINES or NUM_CPUS");
    end

    acc_t                          acc;
    logic                          dist_en;
    logic [NUM_LINES-1:0]          en_vec;
    logic [NUM_LINES-1:0]          pend_vec;
    logic [NUM_LINES-1:0]          rise_vec;
    logic [NUM_LINES-1:0][7:0]     prio_vec;
    logic [NUM_LINES-1:0][NUM_CPUS-1:0] tgt_vec;
    logic [NUM_LINES-1:0][1:0]     cfg_vec;
    logic [7:0]                    rd_byte;

    idist_decode #(.N(NUM_LINES)) u_dec (
        .addr (addr),
        .acc  (acc)
    );

    idist_store #(.N(NUM_LINES), .CPUS(NUM_CPUS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .acc      (acc),
        .wdata    (wdata),
        .ext_irq  (ext_irq),
        .dist_en  (dist_en),
        .en_vec   (en_vec),
        .pend_vec (pend_vec),
        .rise_vec (rise_vec),
        .prio_vec (prio_vec),
        .tgt_vec  (tgt_vec),
        .cfg_vec  (cfg_vec)
    );

    idist_rdmux #(.N(NUM_LINES), .CPUS(NUM_CPUS), .CPU_W(CPU_W)) u_rd (
        .acc      (acc),
        .cpu_id   (cpu_id),
        .dist_en  (dist_en),
        .en_vec   (en_vec),
        .pend_vec (pend_vec),
        .prio_vec (prio_vec),
        .tgt_vec  (tgt_vec),
        .cfg_vec  (cfg_vec),
        .rd_byte  (rd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_byte;
    end
endmodule

// File: rtl/idist_chk.sv
module idist_chk
    import idist_pkg::*;
#(
    parameter int N    = 96,
    parameter int CPUS = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic         rd_en,
    input acc_t         acc,
    input logic [N-1:0] en_vec,
    input logic [N-1:0] pend_vec,
    input logic [N-1:0] rise_vec,
    input logic [7:0]   rdata
);
    localparam logic [7:0] EXP_TYPE = 8'(((N / 32) - 1) | ((CPUS - 1) << 5));

    // R2
    type_value_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && acc.win == WIN_CTRL && acc.ofs == 8'h04) |=> rdata == EXP_TYPE);

    // R4
    fixed_enable_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((en_vec[15:0] & $past(en_vec[15:0])) == $past(en_vec[15:0])));

    // R7
    self_target_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !acc.bad && acc.win == WIN_TARGET && acc.base >= 12'd29 && acc.base <= 12'd31)
        |=> $countones(rdata) == 1);

    // R9
    bad_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc.bad) |=> $stable(en_vec));

    // R9
    bad_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && acc.bad) |=> rdata == 8'h00);

    // R10
    pend_source_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend_vec & ~$past(pend_vec)) != '0)
        |-> ($past(wr_en && acc.win == WIN_SETPND) || ($past(rise_vec) != '0)));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
endmodule

bind idist_regfile idist_chk #(.N(NUM_LINES), .CPUS(NUM_CPUS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .acc      (acc),
    .en_vec   (en_vec),
    .pend_vec (pend_vec),
    .rise_vec (rise_vec),
    .rdata    (rdata)
);

// File: tb/tb_idist_regfile.sv
module tb_idist_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 96;
    localparam int CPUS = 4;
    localparam int PINS = N - 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [11:0]     addr = '0;
    logic [7:0]      wdata = '0;
    logic [1:0]      cpu_id = '0;
    logic [PINS-1:0] ext_irq = '0;
    logic [7:0]      rdata;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    idist_regfile #(.NUM_LINES(N), .NUM_CPUS(CPUS)) dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .cpu_id  (cpu_id),
        .ext_irq (ext_irq),
        .rdata   (rdata)
    );

    // ---------------- behavioural reference model ----------------
    bit m_den;
    bit m_en[N];
    bit m_pend[N];
    int m_prio[N];
    int m_tgt[N];
    int m_cfg[N];
    bit m_prev[PINS];
    int m_rdata;

    function automatic int model_read(int a, int cpu);
        int v = 0;
        int id;
        if (a < 'h100) begin
            if (a == 0) return int'(m_den);
            if (a == 4) return ((N / 32) - 1) + ((CPUS - 1) * 32);
            return 0;
        end
        if (a < 'h300) begin
            int sel = (a - 'h100) / 'h80;
            id = ((a - 'h100) % 'h80) * 8;
            if (id >= N) return 0;
            for (int j = 0; j < 8; j++)
                if ((sel < 2) ? m_en[id + j] : m_pend[id + j]) v += (1 << j);
            return v;
        end
        if (a < 'h400) return 0;
        if (a < 'h800) begin
            id = a - 'h400;
            return (id >= N) ? 0 : m_prio[id];
        end
        if (a < 'hC00) begin
            id = a - 'h800;
            if (id >= N) return 0;
            if (id >= 29 && id <= 31) return (1 << cpu);
            return m_tgt[id];
        end
        if (a < 'hF00) begin
            id = (a - 'hC00) * 4;
            if (id >= N) return 0;
            for (int j = 0; j < 4; j++) v += m_cfg[id + j] << (2 * j);
            return v;
        end
        return 0;
    endfunction

    function automatic void model_write(int a, int d);
        int id;
        if (a == 0) begin
            m_den = d[0];
        end else if (a >= 'h100 && a < 'h300) begin
            int sel = (a - 'h100) / 'h80;
            id = ((a - 'h100) % 'h80) * 8;
            if (id < N) begin
                for (int j = 0; j < 8; j++) begin
                    bit b = d[j];
                    case (sel)
                        0: if (id < 16 || b) m_en[id + j] = 1;
                        1: if (id >= 16 && b) m_en[id + j] = 0;
                        2: if (b) m_pend[id + j] = 1;
                        default: if (b) m_pend[id + j] = 0;
                    endcase
                end
            end
        end else if (a >= 'h400 && a < 'h800) begin
            id = a - 'h400;
            if (id < N) m_prio[id] = d;
        end else if (a >= 'h800 && a < 'hC00) begin
            id = a - 'h800;
            if (id < N && id >= 29) m_tgt[id] = d % (1 << CPUS);
        end else if (a >= 'hC00 && a < 'hF00) begin
            id = (a - 'hC00) * 4;
            if (id < N) begin
                if (id < 32) d = d | 'hAA;
                for (int j = 0; j < 4; j++) m_cfg[id + j] = (d >> (2 * j)) % 4;
            end
        end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_den = 0;
            m_rdata = 0;
            for (int k = 0; k < N; k++) begin
                m_en[k] = 0; m_pend[k] = 0; m_prio[k] = 0; m_tgt[k] = 0; m_cfg[k] = 0;
            end
            for (int p = 0; p < PINS; p++) m_prev[p] = 0;
        end else begin
            if (rd_en) m_rdata = model_read(int'(addr), int'(cpu_id));
            if (wr_en) model_write(int'(addr), int'(wdata));
            for (int p = 0; p < PINS; p++) begin
                if (ext_irq[p] && !m_prev[p]) m_pend[p + 32] = 1;
                m_prev[p] = ext_irq[p];
            end
        end
    end

    // ---------------- per-clock comparison ----------------
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (rdata !== 8'(m_rdata)) begin
                fails++;
                $display("FAIL %s: addr=%03h rdata=%02h expected=%02h",
                         cur_req, addr, rdata, 8'(m_rdata));
            end
        end
    end

    // ---------------- stimulus tasks (called at a falling edge) ----------------
    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [11:0] a);
        cur_req = req;
        addr = a; rd_en = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rdwr(input string req, input logic [11:0] a, input logic [7:0] d);
        cur_req = req;
        addr = a; wdata = d; rd_en = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog R11: cycles actual=20000 expected=fewer");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd("R1", 12'h000); rd("R1", 12'h100); rd("R1", 12'h104);
        rd("R1", 12'h200); rd("R1", 12'h40A); rd("R1", 12'hC00); rd("R1", 12'h828);

        // R2 control window
        rd("R2", 12'h004);
        wr(12'h000, 8'hFF); rd("R2", 12'h000);
        wr(12'h004, 8'h00); rd("R2", 12'h004);
        wr(12'h008, 8'h55); rd("R2", 12'h008);

        // R3 enable windows
        wr(12'h105, 8'hA5); rd("R3", 12'h105); rd("R3", 12'h185);
        wr(12'h185, 8'h21); rd("R3", 12'h105);

        // R4 fixed enables
        wr(12'h100, 8'h00); rd("R4", 12'h100);
        wr(12'h181, 8'hFF); rd("R4", 12'h101); rd("R4", 12'h180);
        rd("R4", 12'h102);

        // R5 pending and active
        wr(12'h20B, 8'h3C); rd("R5", 12'h28B);
        wr(12'h28B, 8'h0C); rd("R5", 12'h20B);
        rd("R5", 12'h300); rd("R5", 12'h30B);

        // R6 priority
        wr(12'h400, 8'h12); wr(12'h45F, 8'hEE);
        rd("R6", 12'h400); rd("R6", 12'h45F); rd("R6", 12'h401);

        // R7 target
        wr(12'h80A, 8'h0F); rd("R7", 12'h80A);
        wr(12'h828, 8'hFB); rd("R7", 12'h828);
        cpu_id = 2'd2; rd("R7", 12'h81E);
        cpu_id = 2'd0; rd("R7", 12'h81D);
        wr(12'h81F, 8'h05); cpu_id = 2'd3; rd("R7", 12'h81F);
        cpu_id = 2'd1; rd("R7", 12'h81C);

        // R8 configuration
        wr(12'hC00, 8'h00); rd("R8", 12'hC00);
        wr(12'hC01, 8'h41); rd("R8", 12'hC01);
        wr(12'hC08, 8'h05); rd("R8", 12'hC08);
        wr(12'hC17, 8'h93); rd("R8", 12'hC17);

        // R9 out of range and unmapped
        wr(12'h460, 8'h77); rd("R9", 12'h460); rd("R9", 12'h45F);
        wr(12'h10C, 8'hFF); rd("R9", 12'h10C);
        wr(12'h20C, 8'hFF); rd("R9", 12'h20C);
        wr(12'hC18, 8'h55); rd("R9", 12'hC18);
        wr(12'h860, 8'h03); rd("R9", 12'h860);
        wr(12'hF00, 8'hFF); rd("R9", 12'hF00); rd("R9", 12'h3FF);
        rd("R9", 12'h000);

        // R10 external edges
        ext_irq[5] = 1'b1; idle(1);
        rd("R10", 12'h204);
        wr(12'h284, 8'h20); idle(2); rd("R10", 12'h204);
        ext_irq[5] = 1'b0; idle(1);
        ext_irq[5] = 1'b1;
        wr(12'h284, 8'h20); rd("R10", 12'h204);
        ext_irq[63] = 1'b1; idle(1); rd("R10", 12'h20B);
        ext_irq[0] = 1'b1; rdwr("R10", 12'h204, 8'h00); rd("R10", 12'h204);

        // R11 read before same-cycle write, and hold
        rdwr("R11", 12'h410, 8'h55); idle(3); rd("R11", 12'h410);
        rdwr("R11", 12'h106, 8'hF0); rd("R11", 12'h106); idle(2);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule